// File: doc/BRIEF.md
# MSI-X table and interrupt dispatcher

This block holds the message-signalled interrupt vector table and the pending-bit array of a platform device that does not sit on PCI. Software reaches both through a 4 KiB register window. The table lives at offset 0x300, with one 16-byte entry for each vector. The pending-bit array lives 256 bytes above the table, at offset 0x400. Access sizes of 4 and 8 bytes are accepted, in little-endian order.

The device core raises per-vector interrupt requests. One mode input selects how every vector is signalled. With the input high, each request becomes a one-cycle pulse on that vector's wired interrupt line. With it low, the request is queued in a per-vector pending register. The block then issues one 32-bit message write through a valid/ready master port, using the address and data held in that vector's table entry. Pending vectors are served lowest index first, one write at a time.

On the master port, a write is offered by raising `mw_valid_o`. The address and data stay unchanged until `mw_ready_i` is seen high at a rising edge. The downstream side may hold ready low for any length of time. Requests that arrive meanwhile are kept pending and are not lost. A vector that is requested again while it is already pending produces only one write.

Top module: `msix_dispatch`

## Requirements
- R1: Each table entry N is four 32-bit words at 0x300+16N, readable and writable with 4-byte accesses. The words are, in order: message address low, message address high, message data, vector control. Read data appears on `reg_rdata_o` in the cycle after the request and is zero in every other cycle.
- R2: An 8-byte access (`reg_size_i`=3) to the table acts on two consecutive words. Bits 31:0 go to the lower address and bits 63:32 to the next word. An 8-byte read returns the two words in the same arrangement.
- R3: The pending-bit array occupies 0x400 to 0x407. Bit N of the word at 0x400 is 1 while vector N waits for its message write. All other bits read as zero. Writes to the array change nothing.
- R4: Some accesses are rejected: a size code other than 2 (4 bytes) or 3 (8 bytes), an address not aligned to the access size, or any byte outside the table and array ranges. A rejected read returns zero, a rejected write changes nothing, and `reg_err_o` is high in the cycle after the request.
- R5: While `wsi_mode_i` is 1, a request on vector N drives `irq_wire_o[N]` high for the following cycle, and no message write is queued for it.
- R6: While `wsi_mode_i` is 0, a request on vector N leads to one write on the master port. The write carries the 64-bit address taken from words 0 and 1 of entry N, and the data taken from word 2, read when the write is launched.
- R7: Once `mw_valid_o` is high, it stays high with `mw_addr_o` and `mw_data_o` unchanged until a cycle in which `mw_ready_i` is 1. The next pending write may start in the cycle right after that handshake.
- R8: When several vectors are pending, their writes are issued in ascending vector order.
- R9: After reset, every table word and every pending bit is zero, and `mw_valid_o` stays low until a request has been taken in message mode.
- R10: `cap_igs_o` reads 2'b11. Bit 0 means wired signalling is supported and bit 1 means message signalling is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one access per high cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset inside the device window |
| reg_size_i | input | 2 | 2 = 4 bytes, 3 = 8 bytes, others rejected |
| reg_wdata_i | input | 64 | Write data, low word at the lower address |
| reg_rdata_o | output | 64 | Read data, one cycle after the request |
| reg_err_o | output | 1 | Rejected access, one cycle after the request |
| wsi_mode_i | input | 1 | 1 = wired pulses, 0 = message writes |
| irq_req_i | input | 5 | Per-vector request, one request per high cycle |
| irq_wire_o | output | 5 | Wired interrupt pulses |
| mw_valid_o | output | 1 | Master write offered |
| mw_ready_i | input | 1 | Master write accepted |
| mw_addr_o | output | 64 | Message address |
| mw_data_o | output | 32 | Message data |
| cap_igs_o | output | 2 | Supported signalling modes |

## Verification
The assertions make no assumption about the order or timing of `mw_ready_i`. They only need `irq_req_i` and the register inputs to be stable at each rising edge, and every check is released while `rst_n` is low. The stimulus changes all inputs only at falling edges. It keeps `reg_addr_i` inside the 12-bit window. It drives ready from fixed patterns and from a pseudo-random sequence, so that writes back up while new requests and table rewrites keep arriving.

// File: rtl/msix_pkg.sv
package msix_pkg;

  typedef enum logic [1:0] {
    SZ_RSV0 = 2'd0,
    SZ_RSV1 = 2'd1,
    SZ_W4   = 2'd2,
    SZ_W8   = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic hit_tbl;
    logic hit_pba;
    logic wide;
  } dec_t;

  // bit0: wired signalling, bit1: message signalling
  localparam logic [1:0] CAP_BOTH = 2'b11;

endpackage

// File: rtl/msix_regdec.sv
module msix_regdec
  import msix_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'h300,
  parameter int TBL_BYTES = 80,
  parameter int PBA_BASE  = 'h400,
  parameter int PBA_BYTES = 8,
  parameter int IDX_W     = 5
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output dec_t              dec_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W:0] TBL_END = (ADDR_W+1)'(TBL_BASE + TBL_BYTES);
  localparam logic [ADDR_W:0] PBA_END = (ADDR_W+1)'(PBA_BASE + PBA_BYTES);

  acc_size_e       sz;
  logic            size_ok;
  logic            aligned;
  logic [ADDR_W:0] last_ex;
  logic            in_tbl;
  logic            in_pba;

  always_comb begin
    sz      = acc_size_e'(size_i);
    size_ok = (sz == SZ_W4) || (sz == SZ_W8);
    aligned = (sz == SZ_W8) ? (addr_i[2:0] == 3'd0) : (addr_i[1:0] == 2'd0);
    last_ex = {1'b0, addr_i} + ((sz == SZ_W8) ? (ADDR_W+1)'(8) : (ADDR_W+1)'(4));
    in_tbl  = (addr_i >= ADDR_W'(TBL_BASE)) && (last_ex <= TBL_END);
    in_pba  = (addr_i >= ADDR_W'(PBA_BASE)) && (last_ex <= PBA_END);

    dec_o.wide    = (sz == SZ_W8);
    dec_o.hit_tbl = req_i && size_ok && aligned && in_tbl;
    dec_o.hit_pba = req_i && size_ok && aligned && in_pba;

    if (in_tbl) idx_o = IDX_W'((addr_i - ADDR_W'(TBL_BASE)) >> 2);
    else        idx_o = IDX_W'((addr_i - ADDR_W'(PBA_BASE)) >> 2);
  end

endmodule

// File: rtl/msix_table.sv
module msix_table #(
  parameter int NUM_VEC = 5,
  parameter int IDX_W   = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [63:0]      wdata_i,
  output logic [31:0]      rd_lo_o,
  output logic [31:0]      rd_hi_o,
  input  logic [SEL_W-1:0] ent_sel_i,
  output logic [63:0]      ent_addr_o,
  output logic [31:0]      ent_data_o
);

  localparam int WORDS = NUM_VEC * 4;

  logic [31:0]    mem [WORDS];
  logic [IDX_W:0] idx_p1;

  assign idx_p1 = {1'b0, idx_i} + (IDX_W+1)'(1);

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (!rst_n) begin
        mem[w] <= '0;
      end else if (wr_en_i && (idx_i == IDX_W'(w))) begin
        mem[w] <= wdata_i[31:0];
      end else if (wr_en_i && wide_i && (idx_p1 == (IDX_W+1)'(w))) begin
        mem[w] <= wdata_i[63:32];
      end
    end
  end

  always_comb begin
    rd_lo_o = '0;
    rd_hi_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (idx_i == IDX_W'(w))        rd_lo_o = mem[w];
      if (idx_p1 == (IDX_W+1)'(w))   rd_hi_o = mem[w];
    end
  end

  logic [63:0] ent_addr [NUM_VEC];
  logic [31:0] ent_data [NUM_VEC];

  for (genvar e = 0; e < NUM_VEC; e++) begin : g_ent
    assign ent_addr[e] = {mem[4*e+1], mem[4*e]};
    assign ent_data[e] = mem[4*e+2];
  end

  always_comb begin
    ent_addr_o = '0;
    ent_data_o = '0;
    for (int e = 0; e < NUM_VEC; e++) begin
      if (ent_sel_i == SEL_W'(e)) begin
        ent_addr_o = ent_addr[e];
        ent_data_o = ent_data[e];
      end
    end
  end

endmodule

// File: rtl/msix_sender.sv
module msix_sender #(
  parameter int NUM_VEC = 5,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req_msg_i,
  output logic [SEL_W-1:0]   ent_sel_o,
  input  logic [63:0]        ent_addr_i,
  input  logic [31:0]        ent_data_i,
  output logic               mw_valid_o,
  input  logic               mw_ready_i,
  output logic [63:0]        mw_addr_o,
  output logic [31:0]        mw_data_o,
  output logic [NUM_VEC-1:0] pend_o
);

  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] lowest;
  logic [NUM_VEC-1:0] grant;
  logic               slot_free;

  assign lowest    = pend_q & (~pend_q + NUM_VEC'(1));
  assign slot_free = !mw_valid_o || mw_ready_i;
  assign grant     = slot_free ? lowest : '0;
  assign pend_o    = pend_q;

  always_comb begin
    ent_sel_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (lowest[i]) ent_sel_o = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      mw_valid_o <= 1'b0;
      mw_addr_o  <= '0;
      mw_data_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | req_msg_i;
      if (grant != '0) begin
        mw_valid_o <= 1'b1;
        mw_addr_o  <= ent_addr_i;
        mw_data_o  <= ent_data_i;
      end else if (mw_ready_i) begin
        mw_valid_o <= 1'b0;
      end
    end
  end

  // R7
  mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid_o && !mw_ready_i) |=> mw_valid_o);

  // R7
  mw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid_o && !mw_ready_i) |=> ($stable(mw_addr_o) && $stable(mw_data_o)));

  // R6
  mw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_valid_o) |-> ($past(pend_q) != '0));

endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch
  import msix_pkg::*;
#(
  parameter int NUM_VEC  = 5,
  parameter int ADDR_W   = 12,
  parameter int TBL_BASE = 'h300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [1:0]         reg_size_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  output logic               reg_err_o,
  input  logic               wsi_mode_i,
  input  logic [NUM_VEC-1:0] irq_req_i,
  output logic [NUM_VEC-1:0] irq_wire_o,
  output logic               mw_valid_o,
  input  logic               mw_ready_i,
  output logic [63:0]        mw_addr_o,
  output logic [31:0]        mw_data_o,
  output logic [1:0]         cap_igs_o
);

  localparam int TBL_BYTES = NUM_VEC * 16;
  localparam int TBL_WORDS = NUM_VEC * 4;
  localparam int PBA_BASE  = TBL_BASE + 256;
  localparam int PBA_BYTES = ((NUM_VEC + 63) / 64) * 8;
  localparam int PBA_WORDS = PBA_BYTES / 4;
  localparam int PBA_BITS  = PBA_BYTES * 8;
  localparam int IDX_W     = $clog2(TBL_WORDS + 1);
  localparam int SEL_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  dec_t               dec;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W:0]     idx_p1;
  logic               acc_ok;
  logic [31:0]        tbl_lo, tbl_hi;
  logic [31:0]        pba_lo, pba_hi;
  logic [31:0]        sel_lo, sel_hi;
  logic [SEL_W-1:0]   ent_sel;
  logic [63:0]        ent_addr;
  logic [31:0]        ent_data;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] req_msg;

  msix_regdec #(
    .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .TBL_BYTES(TBL_BYTES),
    .PBA_BASE(PBA_BASE), .PBA_BYTES(PBA_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .req_i (reg_req_i),
    .addr_i(reg_addr_i),
    .size_i(reg_size_i),
    .dec_o (dec),
    .idx_o (idx)
  );

  assign acc_ok = dec.hit_tbl || dec.hit_pba;
  assign idx_p1 = {1'b0, idx} + (IDX_W+1)'(1);

  msix_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (dec.hit_tbl && reg_we_i),
    .wide_i    (dec.wide),
    .idx_i     (idx),
    .wdata_i   (reg_wdata_i),
    .rd_lo_o   (tbl_lo),
    .rd_hi_o   (tbl_hi),
    .ent_sel_i (ent_sel),
    .ent_addr_o(ent_addr),
    .ent_data_o(ent_data)
  );

  assign req_msg = wsi_mode_i ? '0 : irq_req_i;

  msix_sender #(.NUM_VEC(NUM_VEC), .SEL_W(SEL_W)) u_send (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_msg_i (req_msg),
    .ent_sel_o (ent_sel),
    .ent_addr_i(ent_addr),
    .ent_data_i(ent_data),
    .mw_valid_o(mw_valid_o),
    .mw_ready_i(mw_ready_i),
    .mw_addr_o (mw_addr_o),
    .mw_data_o (mw_data_o),
    .pend_o    (pend)
  );

  // Pending-bit array view: software writes never reach it.
  logic [PBA_BITS-1:0] pba_vec;
  logic [31:0]         pba_word [PBA_WORDS];

  assign pba_vec = PBA_BITS'(pend);

  for (genvar g = 0; g < PBA_WORDS; g++) begin : g_pba
    assign pba_word[g] = pba_vec[32*g +: 32];
  end

  always_comb begin
    pba_lo = '0;
    pba_hi = '0;
    for (int j = 0; j < PBA_WORDS; j++) begin
      if (idx == IDX_W'(j))          pba_lo = pba_word[j];
      if (idx_p1 == (IDX_W+1)'(j))   pba_hi = pba_word[j];
    end
    sel_lo = dec.hit_tbl ? tbl_lo : pba_lo;
    sel_hi = dec.hit_tbl ? tbl_hi : pba_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata_o <= '0;
      reg_err_o   <= 1'b0;
      irq_wire_o  <= '0;
    end else begin
      reg_rdata_o <= (acc_ok && !reg_we_i) ? {dec.wide ? sel_hi : 32'h0, sel_lo} : 64'h0;
      reg_err_o   <= reg_req_i && !acc_ok;
      irq_wire_o  <= wsi_mode_i ? irq_req_i : '0;
    end
  end

  assign cap_igs_o = CAP_BOTH;

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err_o |-> (reg_rdata_o == '0));

  // R5
  wire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wire_o & ~$past(irq_req_i)) == '0);

  // R5
  wire_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wire_o != '0) |-> $past(wsi_mode_i));

endmodule

// File: tb/tb_msix_dispatch.sv
`timescale 1ns/1ps
module tb_msix_dispatch;

  localparam int NV = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_req_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [11:0]   reg_addr_i = '0;
  logic [1:0]    reg_size_i = 2'd2;
  logic [63:0]   reg_wdata_i = '0;
  logic [63:0]   reg_rdata_o;
  logic          reg_err_o;
  logic          wsi_mode_i = 1'b0;
  logic [NV-1:0] irq_req_i = '0;
  logic [NV-1:0] irq_wire_o;
  logic          mw_valid_o;
  logic          mw_ready_i = 1'b1;
  logic [63:0]   mw_addr_o;
  logic [31:0]   mw_data_o;
  logic [1:0]    cap_igs_o;

  always #4 clk = ~clk;

  msix_dispatch dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_size_i(reg_size_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .reg_err_o(reg_err_o),
    .wsi_mode_i(wsi_mode_i), .irq_req_i(irq_req_i), .irq_wire_o(irq_wire_o),
    .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready_i),
    .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o), .cap_igs_o(cap_igs_o)
  );

  // behavioural reference state
  logic [31:0]   m_tab [20];
  logic [NV-1:0] m_pend;
  logic          m_busy;
  logic [63:0]   m_addr;
  logic [31:0]   m_data;
  logic [NV-1:0] m_wire;
  logic [63:0]   m_rd;
  logic          m_err;

  int    compared = 0;
  int    mismatched = 0;
  string tag = "R9";
  bit    ready_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] mword(int a);
    if (a >= 'h300 && a < 'h350) return m_tab[(a - 'h300) / 4];
    if (a == 'h400) return {{(32-NV){1'b0}}, m_pend};
    return 32'h0;
  endfunction

  always @(posedge clk) begin : ref_model
    int            a;
    int            nb;
    int            sel;
    bit            ok;
    logic [NV-1:0] np;
    logic [63:0]   rd;
    if (!rst_n) begin
      for (int i = 0; i < 20; i++) m_tab[i] = '0;
      m_pend = '0; m_busy = 1'b0; m_addr = '0; m_data = '0;
      m_wire = '0; m_rd = '0; m_err = 1'b0;
    end else begin
      a  = int'(reg_addr_i);
      nb = (reg_size_i == 2'd2) ? 4 : ((reg_size_i == 2'd3) ? 8 : 0);
      ok = (nb != 0) && ((a % nb) == 0) &&
           ((a >= 'h300 && a + nb <= 'h350) || (a >= 'h400 && a + nb <= 'h408));
      rd = (reg_req_i && !reg_we_i && ok) ?
           {(nb == 8) ? mword(a + 4) : 32'h0, mword(a)} : 64'h0;
      np = m_pend;
      if (!m_busy || mw_ready_i) begin
        m_busy = 1'b0;
        sel = 0;
        for (int k = NV - 1; k >= 0; k--) if (m_pend[k]) sel = k;
        if (m_pend != '0) begin
          m_addr = {m_tab[4*sel+1], m_tab[4*sel]};
          m_data = m_tab[4*sel+2];
          m_busy = 1'b1;
          np[sel] = 1'b0;
        end
      end
      if (!wsi_mode_i) np = np | irq_req_i;
      if (reg_req_i && reg_we_i && ok && a < 'h400) begin
        m_tab[(a - 'h300) / 4] = reg_wdata_i[31:0];
        if (nb == 8) m_tab[(a - 'h300) / 4 + 1] = reg_wdata_i[63:32];
      end
      m_pend = np;
      m_wire = wsi_mode_i ? irq_req_i : '0;
      m_rd   = rd;
      m_err  = reg_req_i && !ok;
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("irq_wire_o", 64'(irq_wire_o), 64'(m_wire));
    chk("mw_valid_o", 64'(mw_valid_o), 64'(m_busy));
    if (m_busy && mw_valid_o) begin
      chk("mw_addr_o", mw_addr_o, m_addr);
      chk("mw_data_o", 64'(mw_data_o), 64'(m_data));
    end
    chk("reg_rdata_o", reg_rdata_o, m_rd);
    chk("reg_err_o", 64'(reg_err_o), 64'(m_err));
    chk("cap_igs_o", 64'(cap_igs_o), 64'(2'b11));
  endtask

  task automatic tick();
    if (ready_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mw_ready_i = lfsr[0];
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic bus(bit we, int addr, logic [1:0] sz, logic [63:0] wd);
    reg_req_i   = 1'b1;
    reg_we_i    = we;
    reg_addr_i  = 12'(addr);
    reg_size_i  = sz;
    reg_wdata_i = wd;
    tick();
    reg_req_i = 1'b0;
    reg_we_i  = 1'b0;
  endtask

  task automatic fire(logic [NV-1:0] mask);
    irq_req_i = mask;
    tick();
    irq_req_i = '0;
  endtask

  initial begin : watchdog
    #1600000;
    mismatched++;
    $display("FAIL %s watchdog expired: actual hung expected finished", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    // R9: reset state
    tag = "R9";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    for (int w = 0; w < 20; w++) bus(1'b0, 'h300 + 4*w, 2'd2, '0);
    bus(1'b0, 'h400, 2'd3, '0);

    // R1: 4-byte table access
    tag = "R1";
    for (int e = 0; e < NV; e++) begin
      bus(1'b1, 'h300 + 16*e,      2'd2, 64'(32'h1000_0000 + 32'(e) * 32'h100));
      bus(1'b1, 'h300 + 16*e + 4,  2'd2, 64'(32'h0000_00A0 + 32'(e)));
      bus(1'b1, 'h300 + 16*e + 8,  2'd2, 64'(32'hCAFE_0000 + 32'(e)));
      bus(1'b1, 'h300 + 16*e + 12, 2'd2, 64'(32'h1 ^ 32'(e)));
    end
    for (int w = 0; w < 20; w++) bus(1'b0, 'h300 + 4*w, 2'd2, '0);

    // R2: 8-byte halves
    tag = "R2";
    bus(1'b1, 'h320, 2'd3, 64'h0000_00BB_2222_0040);
    bus(1'b0, 'h320, 2'd3, '0);
    bus(1'b0, 'h320, 2'd2, '0);
    bus(1'b0, 'h324, 2'd2, '0);
    bus(1'b1, 'h348, 2'd3, 64'h1234_5678_9ABC_DEF0);
    bus(1'b0, 'h348, 2'd3, '0);
    bus(1'b0, 'h34C, 2'd2, '0);

    // R4: rejected accesses
    tag = "R4";
    bus(1'b0, 'h350, 2'd2, '0);
    bus(1'b1, 'h350, 2'd2, 64'hFFFF_FFFF);
    bus(1'b0, 'h2FC, 2'd2, '0);
    bus(1'b0, 'h302, 2'd2, '0);
    bus(1'b0, 'h304, 2'd3, '0);
    bus(1'b1, 'h304, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
    bus(1'b0, 'h300, 2'd0, '0);
    bus(1'b1, 'h300, 2'd1, 64'hFFFF_FFFF);
    bus(1'b0, 'h300, 2'd2, '0);
    bus(1'b0, 'h304, 2'd2, '0);
    bus(1'b0, 'h408, 2'd2, '0);
    bus(1'b0, 'h404, 2'd3, '0);
    bus(1'b0, 'h000, 2'd2, '0);

    // R5: wired pulses
    tag = "R5";
    wsi_mode_i = 1'b1;
    fire(5'b00001);
    tick();
    fire(5'b10000);
    fire(5'b01010);
    repeat (3) tick();
    bus(1'b0, 'h400, 2'd2, '0);

    // R6: message writes
    tag = "R6";
    wsi_mode_i = 1'b0;
    mw_ready_i = 1'b1;
    fire(5'b00100);
    repeat (3) tick();
    fire(5'b00001);
    repeat (3) tick();

    // R7: back-pressure
    tag = "R7";
    mw_ready_i = 1'b0;
    fire(5'b01000);
    repeat (4) tick();
    fire(5'b01000);
    repeat (2) tick();
    mw_ready_i = 1'b1;
    repeat (4) tick();

    // R3: pending-bit array under back-pressure
    tag = "R3";
    mw_ready_i = 1'b0;
    fire(5'b10110);
    fire(5'b00001);
    bus(1'b0, 'h400, 2'd2, '0);
    bus(1'b0, 'h400, 2'd3, '0);
    bus(1'b1, 'h400, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus(1'b0, 'h400, 2'd2, '0);
    bus(1'b1, 'h404, 2'd2, 64'hFFFF_FFFF);
    bus(1'b0, 'h404, 2'd2, '0);

    // R8: ascending order drain
    tag = "R8";
    mw_ready_i = 1'b1;
    repeat (8) tick();

    // R7: random ready with traffic and table rewrites
    tag = "R7";
    ready_rand = 1'b1;
    for (int n = 0; n < 60; n++) begin
      irq_req_i  = lfsr[NV+2:3];
      wsi_mode_i = (lfsr[9:8] == 2'b11);
      if (lfsr[5]) bus(1'b1, 'h308 + 16 * (n % NV), 2'd2, 64'(32'hA000_0000 + 32'(n)));
      else tick();
      irq_req_i = '0;
      if (n % 7 == 0) bus(1'b0, 'h400, 2'd2, '0);
    end
    ready_rand = 1'b0;
    wsi_mode_i = 1'b0;
    mw_ready_i = 1'b1;
    repeat (10) tick();

    // R10: capability code
    tag = "R10";
    repeat (2) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule